// File: doc/BRIEF.md
# RTC Alarm Match and Interrupt Control

This block sits beside a real-time clock's calendar counter. Software loads a set of alarm settings: seconds, minutes, hours, day of week, day of month, month and year, all in BCD. The block compares the enabled settings with the running time once per one-second tick. When every enabled field equals the current time, it sets a sticky alarm flag. A second sticky flag records carry events reported by the calendar counter.

Both flags live in a control register together with two interrupt enables. Each interrupt output is a level signal that stays high while its flag and its enable are both 1. Software acknowledges a flag by writing 0 to its bit. Writing 1 to a flag bit leaves that flag unchanged, so a read-modify-write of the enables cannot accidentally clear a pending event.

The register port is a single-cycle write strobe with a combinational read. The calendar counter and the prescaler that produce the time fields, the tick and the carry event are outside the block.

Top module: `rtc_alarm_ctl`

## Requirements
- R1: After reset the control register (address 8) and the year control register (address 9) read 0, and both interrupt outputs are low.
- R2: The alarm flag (control bit 0) becomes 1 in the cycle after a `sec_tick` cycle in which every enabled alarm field equals its current time input. Alarm registers are at addresses 0 (seconds), 1 (minutes), 2 (hours), 3 (day of week), 4 (day) and 5 (month); each has its field enable in bit 7 and its value in the low bits.
- R3: A field whose enable bit is 0 does not take part in the comparison. When no field is enabled, a tick never sets the alarm flag.
- R4: The year value (address 6, 8 bits of BCD) takes part only when both the year field enable (address 7, bit 7) and the global year enable (address 9, bit 0) are 1.
- R5: Writing the control register with bit 0 = 0 clears the alarm flag. Writing it with bit 0 = 1 leaves the flag unchanged.
- R6: If a match tick and a write of 0 to the alarm flag fall in the same cycle, the flag ends up 1.
- R7: A `carry_evt` pulse sets the carry flag (control bit 1). A write of 0 to bit 1 clears it, a write of 1 keeps it, and a pulse in the same cycle as a clear leaves the flag at 1.
- R8: `alm_irq` is high exactly while the alarm flag and the alarm interrupt enable (control bit 4) are both 1.
- R9: `cry_irq` is high exactly while the carry flag and the carry interrupt enable (control bit 5) are both 1.
- R10: Reserved bits (control bits 2, 3, 6 and 7; year control bits 7 to 1) always read 0, and writes to them have no effect.
- R11: Without a `sec_tick`, the alarm flag is not set, even while the enabled fields match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD |
| now_wday | input | 3 | Current day of week |
| now_day | input | 6 | Current day of month, BCD |
| now_mon | input | 5 | Current month, BCD |
| now_year | input | 8 | Current year, two BCD digits |
| sec_tick | input | 1 | One-second tick, high in the cycle the time is already updated |
| carry_evt | input | 1 | Carry event pulse from the calendar counter |
| alm_irq | output | 1 | Alarm interrupt level |
| cry_irq | output | 1 | Carry interrupt level |

## Verification
Two events can land on the same cycle. A match tick and a software write of 0 to the alarm flag can arrive together, and so can a carry pulse and a write of 0 to the carry flag. The bench forces each collision by raising the tick, or the carry pulse, on the same clock edge as the clearing write. Afterwards it reads the control register: the flag must still be 1, because the set has priority over the clear. A separate write of 0 that arrives with no event must then clear the flag, which shows that the clear path itself works.

// File: rtl/rtc_alarm_ctl.sv
module rtc_alarm_ctl #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [6:0]    now_sec,
  input  logic [6:0]    now_min,
  input  logic [5:0]    now_hour,
  input  logic [2:0]    now_wday,
  input  logic [5:0]    now_day,
  input  logic [4:0]    now_mon,
  input  logic [7:0]    now_year,
  input  logic          sec_tick,
  input  logic          carry_evt,
  output logic          alm_irq,
  output logic          cry_irq
);

  localparam logic [AW-1:0] A_SEC  = AW'(0);
  localparam logic [AW-1:0] A_MIN  = AW'(1);
  localparam logic [AW-1:0] A_HOUR = AW'(2);
  localparam logic [AW-1:0] A_WDAY = AW'(3);
  localparam logic [AW-1:0] A_DAY  = AW'(4);
  localparam logic [AW-1:0] A_MON  = AW'(5);
  localparam logic [AW-1:0] A_YEAR = AW'(6);
  localparam logic [AW-1:0] A_YFEN = AW'(7);
  localparam logic [AW-1:0] A_CTL  = AW'(8);
  localparam logic [AW-1:0] A_CTL2 = AW'(9);

  logic [7:0] al_sec, al_min, al_hour, al_wday, al_day, al_mon, al_year;
  logic       yr_fld_en, yr_glb_en;
  logic       af, cf, aie, cie;

  wire ctl_wr = reg_wr && (reg_addr == A_CTL);
  wire yr_act = yr_fld_en && yr_glb_en;

  wire ok_sec  = !al_sec[7]  || (al_sec[6:0]  == now_sec);
  wire ok_min  = !al_min[7]  || (al_min[6:0]  == now_min);
  wire ok_hour = !al_hour[7] || (al_hour[5:0] == now_hour);
  wire ok_wday = !al_wday[7] || (al_wday[2:0] == now_wday);
  wire ok_day  = !al_day[7]  || (al_day[5:0]  == now_day);
  wire ok_mon  = !al_mon[7]  || (al_mon[4:0]  == now_mon);
  wire ok_year = !yr_act     || (al_year      == now_year);

  wire any_en = al_sec[7] | al_min[7] | al_hour[7] | al_wday[7] |
                al_day[7] | al_mon[7] | yr_act;
  wire hit = any_en & ok_sec & ok_min & ok_hour & ok_wday & ok_day & ok_mon & ok_year;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_sec    <= '0;
      al_min    <= '0;
      al_hour   <= '0;
      al_wday   <= '0;
      al_day    <= '0;
      al_mon    <= '0;
      al_year   <= '0;
      yr_fld_en <= 1'b0;
      yr_glb_en <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_SEC:   al_sec    <= reg_wdata;
        A_MIN:   al_min    <= reg_wdata;
        A_HOUR:  al_hour   <= reg_wdata & 8'hBF;
        A_WDAY:  al_wday   <= reg_wdata & 8'h87;
        A_DAY:   al_day    <= reg_wdata & 8'hBF;
        A_MON:   al_mon    <= reg_wdata & 8'h9F;
        A_YEAR:  al_year   <= reg_wdata;
        A_YFEN:  yr_fld_en <= reg_wdata[7];
        A_CTL2:  yr_glb_en <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af  <= 1'b0;
      cf  <= 1'b0;
      aie <= 1'b0;
      cie <= 1'b0;
    end else begin
      if (sec_tick && hit)             af <= 1'b1;
      else if (ctl_wr && !reg_wdata[0]) af <= 1'b0;
      if (carry_evt)                   cf <= 1'b1;
      else if (ctl_wr && !reg_wdata[1]) cf <= 1'b0;
      if (ctl_wr) begin
        aie <= reg_wdata[4];
        cie <= reg_wdata[5];
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_SEC:   reg_rdata = al_sec;
      A_MIN:   reg_rdata = al_min;
      A_HOUR:  reg_rdata = al_hour;
      A_WDAY:  reg_rdata = al_wday;
      A_DAY:   reg_rdata = al_day;
      A_MON:   reg_rdata = al_mon;
      A_YEAR:  reg_rdata = al_year;
      A_YFEN:  reg_rdata = {yr_fld_en, 7'b0};
      A_CTL:   reg_rdata = {2'b00, cie, aie, 2'b00, cf, af};
      A_CTL2:  reg_rdata = {7'b0, yr_glb_en};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign alm_irq = af & aie;
  assign cry_irq = cf & cie;

  AST_AF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(af) |-> $past(sec_tick)); // R11
  AST_AF_W1_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[0] && af) |=> af); // R5
  AST_AF_W0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !reg_wdata[0] && !sec_tick) |=> !af); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && hit) |=> af); // R6
  AST_NO_FIELD_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!af && !any_en) |=> !af); // R3
  AST_CF_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cf) |-> $past(carry_evt)); // R7
  AST_CRY_IRQ_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !reg_wdata[5]) |=> !cry_irq); // R9

endmodule

// File: tb/rtc_alarm_ctl_bench.sv
module rtc_alarm_ctl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [6:0] now_sec = 7'h56, now_min = 7'h34;
  logic [5:0] now_hour = 6'h12, now_day = 6'h21;
  logic [2:0] now_wday = 3'd3;
  logic [4:0] now_mon = 5'h09;
  logic [7:0] now_year = 8'h24;
  logic sec_tick = 1'b0, carry_evt = 1'b0;
  logic alm_irq, cry_irq;
  int total = 0, bad = 0;

  rtc_alarm_ctl #(.AW(4)) u_rtc_alarm_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .now_sec(now_sec),
    .now_min(now_min), .now_hour(now_hour), .now_wday(now_wday),
    .now_day(now_day), .now_mon(now_mon), .now_year(now_year),
    .sec_tick(sec_tick), .carry_evt(carry_evt), .alm_irq(alm_irq), .cry_irq(cry_irq));

  always #10 clk = ~clk;

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [3:0] a, input logic [7:0] d,
                      input logic tk, input logic ce);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; sec_tick = tk; carry_evt = ce;
    @(negedge clk);
    reg_wr = 1'b0; sec_tick = 1'b0; carry_evt = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic clear_all;
    for (int i = 0; i < 8; i++) wr(4'(i), 8'h00);
    wr(4'd9, 8'h00);
    wr(4'd8, 8'h00);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(4'd8, v); chk(v, 8'h00, "R1 ctl");
    rd(4'd9, v); chk(v, 8'h00, "R1 ctl2");
    chk({7'b0, alm_irq}, 8'h00, "R1 alm_irq");
    chk({7'b0, cry_irq}, 8'h00, "R1 cry_irq");
  endtask

  task automatic t_match;
    logic [7:0] v;
    clear_all();
    wr(4'd0, 8'h80 | 8'h56);
    wr(4'd1, 8'h80 | 8'h34);
    step(1'b0, 4'd8, 8'h00, 1'b0, 1'b0);
    rd(4'd8, v); chk(v & 8'h01, 8'h00, "R11 no tick");
    step(1'b0, 4'd8, 8'h00, 1'b1, 1'b0);
    rd(4'd8, v); chk(v & 8'h01, 8'h01, "R2 match set");
    wr(4'd8, 8'h00);
    now_sec = 7'h57;
    step(1'b0, 4'd8, 8'h00, 1'b1, 1'b0);
    rd(4'd8, v); chk(v & 8'h01, 8'h00, "R2 mismatch");
    now_sec = 7'h56;
  endtask

  task automatic t_disabled;
    logic [7:0] v;
    clear_all();
    wr(4'd0, 8'hD6);
    wr(4'd1, 8'h11);
    wr(4'd2, 8'h3F);
    step(1'b0, 4'd8, 8'h00, 1'b1, 1'b0);
    rd(4'd8, v); chk(v & 8'h01, 8'h01, "R3 disabled field ignored");
    clear_all();
    wr(4'd0, 8'h56);
    step(1'b0, 4'd8, 8'h00, 1'b1, 1'b0);
    rd(4'd8, v); chk(v & 8'h01, 8'h00, "R3 none enabled");
  endtask

  task automatic t_year;
    logic [7:0] v;
    clear_all();
    wr(4'd6, 8'h24);
    wr(4'd7, 8'h80);
    step(1'b0, 4'd8, 8'h00, 1'b1, 1'b0);
    rd(4'd8, v); chk(v & 8'h01, 8'h00, "R4 global off");
    wr(4'd9, 8'h01);
    step(1'b0, 4'd8, 8'h00, 1'b1, 1'b0);
    rd(4'd8, v); chk(v & 8'h01, 8'h01, "R4 both on");
    wr(4'd8, 8'h00);
    wr(4'd7, 8'h00);
    step(1'b0, 4'd8, 8'h00, 1'b1, 1'b0);
    rd(4'd8, v); chk(v & 8'h01, 8'h00, "R4 field off");
    wr(4'd7, 8'h80);
    wr(4'd0, 8'hD6);
    now_year = 8'h25;
    step(1'b0, 4'd8, 8'h00, 1'b1, 1'b0);
    rd(4'd8, v); chk(v & 8'h01, 8'h00, "R4 year mismatch");
    now_year = 8'h24;
  endtask

  task automatic t_clear;
    logic [7:0] v;
    clear_all();
    wr(4'd0, 8'hD6);
    step(1'b0, 4'd8, 8'h00, 1'b1, 1'b0);
    wr(4'd8, 8'h01);
    rd(4'd8, v); chk(v & 8'h01, 8'h01, "R5 write1 keeps");
    wr(4'd8, 8'h00);
    rd(4'd8, v); chk(v & 8'h01, 8'h00, "R5 write0 clears");
  endtask

  task automatic t_collide;
    logic [7:0] v;
    clear_all();
    wr(4'd0, 8'hD6);
    step(1'b0, 4'd8, 8'h00, 1'b1, 1'b0);
    step(1'b1, 4'd8, 8'h00, 1'b1, 1'b0);
    rd(4'd8, v); chk(v & 8'h01, 8'h01, "R6 set wins");
    wr(4'd8, 8'h00);
    rd(4'd8, v); chk(v & 8'h01, 8'h00, "R6 later clear");
  endtask

  task automatic t_carry;
    logic [7:0] v;
    clear_all();
    step(1'b0, 4'd8, 8'h00, 1'b0, 1'b1);
    rd(4'd8, v); chk(v & 8'h02, 8'h02, "R7 set");
    wr(4'd8, 8'h02);
    rd(4'd8, v); chk(v & 8'h02, 8'h02, "R7 write1 keeps");
    wr(4'd8, 8'h00);
    rd(4'd8, v); chk(v & 8'h02, 8'h00, "R7 write0 clears");
    step(1'b1, 4'd8, 8'h00, 1'b0, 1'b1);
    rd(4'd8, v); chk(v & 8'h02, 8'h02, "R7 pulse beats clear");
    wr(4'd8, 8'h00);
  endtask

  task automatic t_irq;
    clear_all();
    wr(4'd0, 8'hD6);
    step(1'b0, 4'd8, 8'h00, 1'b1, 1'b0);
    chk({7'b0, alm_irq}, 8'h00, "R8 enable off");
    wr(4'd8, 8'h11);
    chk({7'b0, alm_irq}, 8'h01, "R8 flag and enable");
    wr(4'd8, 8'h10);
    chk({7'b0, alm_irq}, 8'h00, "R8 flag cleared");
    step(1'b0, 4'd8, 8'h00, 1'b0, 1'b1);
    chk({7'b0, cry_irq}, 8'h00, "R9 enable off");
    wr(4'd8, 8'h23);
    chk({7'b0, cry_irq}, 8'h01, "R9 flag and enable");
    wr(4'd8, 8'h03);
    chk({7'b0, cry_irq}, 8'h00, "R9 enable cleared");
    wr(4'd8, 8'h00);
  endtask

  task automatic t_reserved;
    logic [7:0] v;
    clear_all();
    wr(4'd8, 8'hFF);
    rd(4'd8, v); chk(v, 8'h30, "R10 ctl reserved");
    wr(4'd9, 8'hFE);
    rd(4'd9, v); chk(v, 8'h00, "R10 ctl2 reserved");
    wr(4'd9, 8'hFF);
    rd(4'd9, v); chk(v, 8'h01, "R10 ctl2 enable only");
    wr(4'd8, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_match();
    t_disabled();
    t_year();
    t_clear();
    t_collide();
    t_carry();
    t_irq();
    t_reserved();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule